// File: doc/BRIEF.md
# Aligned Segment Chunker

This block sits between a producer of scatter-gather segments and a transfer engine whose count register holds at most 13 bits. It receives a stream of (address, length) segments that together form one list, the last segment being flagged. It emits a stream of sub-segments that each fit the engine's count limit. A segment that is too long is not cut greedily into full-size pieces plus a small leftover. Instead it is divided into roughly equal pieces whose lengths are multiples of four bytes, so the engine never receives a very short final piece.

Splitting uses a sequential restoring divider. Two divisions are made for each oversized piece: the piece count for the remaining length, then the piece length. While a segment is being split the input is stalled. When the list closes, the last output beat also carries the byte total of the original segments and the number of sub-segments emitted. A segment with a misaligned address or a zero length rejects the whole list. In that case the rest of the list is consumed from the input and a single error beat closes it.

Top module: `seg_chunker`

## Requirements
- R1: A segment whose remaining length is 8191 (0x1FFF) or less is emitted as one sub-segment with that length at its current address.
- R2: While the remaining length R exceeds 8191, the emitted length is floor(R / M) with bits [1:0] cleared, where M = ceil(R / 8188). The rule is applied again to what remains.
- R3: Each sub-segment of a segment starts at the previous start address plus the previous length. The lengths of a segment's sub-segments add up to the segment length.
- R4: Every non-error output beat has a length between 1 and 8191.
- R5: `out_last` is 1 only on the final sub-segment of the segment that arrived with `in_last`, or on an error beat.
- R6: A segment with address bits [1:0] not both zero, or with length 0, rejects the list. No further sub-segments of that list are emitted. Input beats are accepted and discarded up to the one carrying `in_last`. Then one beat is emitted with `out_err`=1, `out_last`=1, `out_len`=0 and `out_addr`=0.
- R7: A list made of a single zero-length segment, which is the empty list, produces only the error beat of R6, with a total of 0 and a count of 0.
- R8: On the closing beat, `out_total` is the sum of the original lengths of the accepted segments and `out_count` is the number of sub-segments of the list including that beat. On an error beat, only the segments and sub-segments before the rejected segment are counted.
- R9: `in_ready` is 0 whenever `out_valid` is 1 or a division is in progress.
- R10: While `out_valid`=1 and `out_ready`=0, the output beat holds its value into the next cycle.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input segment valid |
| in_ready | output | 1 | Block can take a segment |
| in_addr | input | ADDR_W (32) | Segment start address |
| in_len | input | LEN_W (16) | Segment length in bytes |
| in_last | input | 1 | Segment is the last of its list |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_addr | output | ADDR_W (32) | Sub-segment start address |
| out_len | output | CHUNK_W (13) | Sub-segment length |
| out_last | output | 1 | Closing beat of the list |
| out_err | output | 1 | List rejected (error beat) |
| out_total | output | TOTAL_W (24) | Byte total, valid on closing beat |
| out_count | output | COUNT_W (10) | Sub-segment count, valid on closing beat |

## Verification
Some properties are checked on every cycle. Output beats stay within the length limit and hold while stalled. Every sub-segment address is four-byte aligned, so no misaligned piece can leak out. Each finished division yields a quotient q with q times the divisor at most the dividend and (q+1) times the divisor above it. A closing beat that is not an error never reports a count of zero. Other behaviour needs the bench's scenarios to show it: the exact near-equal piece lengths, address advance and totals for random lists, the draining of the rest of a rejected list, and the empty list.

// File: rtl/split_pkg.sv
// Shared types for the segment chunker.
// Assumes: included first in compile order.
package split_pkg;

    // Control states of the chunker sequencer.
    typedef enum logic [2:0] {
        ST_TAKE,      // waiting for an input segment
        ST_PLAN,      // decide whole emit or start piece-count division
        ST_DIV_MULT,  // piece-count division running
        ST_DIV_LEN,   // piece-length division running
        ST_EMIT,      // presenting a sub-segment
        ST_DRAIN,     // discarding rest of a rejected list
        ST_FAULT      // presenting the error beat
    } split_state_e;

endpackage

// File: rtl/split_divider.sv
// Restoring unsigned divider, one quotient bit per cycle.
// Assumes: divisor is never zero when start is given; start is taken
// only while idle; done pulses for one cycle with the quotient valid
// and the unit idle again in that same cycle.
module split_divider #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [W-1:0]  num_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          done_q;
    logic [W:0]    trial;

    // Partial remainder shifted left with the next dividend bit.
    always_comb begin
        trial = {rem_q, quo_q[W-1]};
    end

    // Iteration register: load on start, one subtract-or-shift per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            num_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                den_q  <= divisor;
                num_q  <= dividend;
                cnt_q  <= CW'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (trial >= {1'b0, den_q}) begin
                    rem_q <= W'(trial - {1'b0, den_q});
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign quotient = quo_q;

    // R2: the quotient handed out is the exact floor of the division.
    a_r2_quotient_exact: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (({{W{1'b0}}, quotient} * {{W{1'b0}}, den_q}) <= {{W{1'b0}}, num_q}) &&
                 ((({{W{1'b0}}, quotient} + 1'b1) * {{W{1'b0}}, den_q}) > {{W{1'b0}}, num_q}));

endmodule

// File: rtl/split_tally.sv
// Per-list byte total and sub-segment count.
// Assumes: clear marks the closing beat and wins over a chunk in the
// same cycle; add and chunk never coincide (input stalls while emitting).
module split_tally #(
    parameter int LEN_W   = 16,
    parameter int TOTAL_W = 24,
    parameter int COUNT_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               add_en,
    input  logic [LEN_W-1:0]   add_len,
    input  logic               chunk_en,
    input  logic               clear,
    output logic [TOTAL_W-1:0] total,
    output logic [COUNT_W-1:0] count
);
    logic [TOTAL_W-1:0] total_q;
    logic [COUNT_W-1:0] count_q;

    // Accumulate accepted lengths and emitted pieces; restart per list.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            total_q <= '0;
            count_q <= '0;
        end else begin
            if (add_en) begin
                total_q <= total_q + TOTAL_W'(add_len);
            end
            if (chunk_en) begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    assign total = total_q;
    assign count = count_q;

endmodule

// File: rtl/seg_chunker.sv
// Splits a list of (address, length) segments into sub-segments whose
// length fits CHUNK_W bits. Oversized remainders are cut into near-equal
// pieces aligned to 2**ALIGN_BITS bytes using a sequential divider.
// Assumes: LEN_W >= CHUNK_W; one list is closed by the beat with in_last.
module seg_chunker
    import split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int CHUNK_W    = 13,
    parameter int ALIGN_BITS = 2,
    parameter int TOTAL_W    = 24,
    parameter int COUNT_W    = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [LEN_W-1:0]   in_len,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [CHUNK_W-1:0] out_len,
    output logic               out_last,
    output logic               out_err,
    output logic [TOTAL_W-1:0] out_total,
    output logic [COUNT_W-1:0] out_count
);
    localparam int MAX_LEN    = (1 << CHUNK_W) - 1;
    localparam int ALIGN_MASK = (1 << ALIGN_BITS) - 1;
    localparam int STEP       = MAX_LEN & ~ALIGN_MASK;
    localparam int DW         = LEN_W + 1;

    split_state_e       state_q;
    logic [ADDR_W-1:0]  cur_addr_q;
    logic [LEN_W-1:0]   cur_rem_q;
    logic               seg_last_q;
    logic [CHUNK_W-1:0] chunk_len_q;

    logic               in_fire;
    logic               out_fire;
    logic               seg_bad;
    logic               oversize;
    logic               final_piece;
    logic               div_start;
    logic [DW-1:0]      div_a;
    logic [DW-1:0]      div_b;
    logic               div_busy;
    logic               div_done;
    logic [DW-1:0]      div_q;
    logic [TOTAL_W-1:0] tally_total;
    logic [COUNT_W-1:0] tally_count;

    // Handshake and decision terms for the sequencer.
    always_comb begin
        in_ready    = (state_q == ST_TAKE) || (state_q == ST_DRAIN);
        out_valid   = (state_q == ST_EMIT) || (state_q == ST_FAULT);
        in_fire     = in_valid && in_ready;
        out_fire    = out_valid && out_ready;
        seg_bad     = (in_len == '0) || (in_addr[ALIGN_BITS-1:0] != '0);
        oversize    = cur_rem_q > LEN_W'(MAX_LEN);
        final_piece = cur_rem_q == LEN_W'(chunk_len_q);
    end

    // Divider operand selection: piece count first, then piece length.
    always_comb begin
        div_start = 1'b0;
        div_a     = {1'b0, cur_rem_q};
        div_b     = DW'(STEP);
        if (state_q == ST_PLAN && oversize) begin
            div_start = 1'b1;
            div_a     = {1'b0, cur_rem_q} + DW'(STEP - 1);
            div_b     = DW'(STEP);
        end else if (state_q == ST_DIV_MULT && div_done) begin
            div_start = 1'b1;
            div_a     = {1'b0, cur_rem_q};
            div_b     = div_q;
        end
    end

    // Sequencer: accept, plan, divide, emit, or drain a rejected list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_TAKE;
            cur_addr_q  <= '0;
            cur_rem_q   <= '0;
            seg_last_q  <= 1'b0;
            chunk_len_q <= '0;
        end else begin
            case (state_q)
                ST_TAKE: begin
                    if (in_fire) begin
                        if (seg_bad) begin
                            state_q <= in_last ? ST_FAULT : ST_DRAIN;
                        end else begin
                            cur_addr_q <= in_addr;
                            cur_rem_q  <= in_len;
                            seg_last_q <= in_last;
                            state_q    <= ST_PLAN;
                        end
                    end
                end
                ST_PLAN: begin
                    if (oversize) begin
                        state_q <= ST_DIV_MULT;
                    end else begin
                        chunk_len_q <= CHUNK_W'(cur_rem_q);
                        state_q     <= ST_EMIT;
                    end
                end
                ST_DIV_MULT: begin
                    if (div_done) begin
                        state_q <= ST_DIV_LEN;
                    end
                end
                ST_DIV_LEN: begin
                    if (div_done) begin
                        chunk_len_q <= CHUNK_W'(div_q) & ~CHUNK_W'(ALIGN_MASK);
                        state_q     <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (out_fire) begin
                        cur_addr_q <= cur_addr_q + ADDR_W'(chunk_len_q);
                        cur_rem_q  <= cur_rem_q - LEN_W'(chunk_len_q);
                        state_q    <= final_piece ? ST_TAKE : ST_PLAN;
                    end
                end
                ST_DRAIN: begin
                    if (in_fire && in_last) begin
                        state_q <= ST_FAULT;
                    end
                end
                ST_FAULT: begin
                    if (out_fire) begin
                        state_q <= ST_TAKE;
                    end
                end
                default: state_q <= ST_TAKE;
            endcase
        end
    end

    split_divider #(.W(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_a),
        .divisor  (div_b),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_q)
    );

    split_tally #(.LEN_W(LEN_W), .TOTAL_W(TOTAL_W), .COUNT_W(COUNT_W)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (in_fire && (state_q == ST_TAKE) && !seg_bad),
        .add_len  (in_len),
        .chunk_en (out_fire && (state_q == ST_EMIT)),
        .clear    (out_fire && out_last),
        .total    (tally_total),
        .count    (tally_count)
    );

    // Output beat assembly: sub-segment or error beat.
    always_comb begin
        out_err   = (state_q == ST_FAULT);
        out_addr  = out_err ? '0 : cur_addr_q;
        out_len   = out_err ? '0 : chunk_len_q;
        out_last  = out_err || ((state_q == ST_EMIT) && final_piece && seg_last_q);
        out_total = tally_total;
        out_count = (state_q == ST_EMIT) ? tally_count + 1'b1 : tally_count;
    end

    // R4: sub-segment lengths stay within 1..MAX_LEN.
    a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_len != '0) && (int'(out_len) <= MAX_LEN));

    // R3: every sub-segment starts on an aligned address.
    a_r3_chunk_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_addr[ALIGN_BITS-1:0] == '0));

    // R10: a stalled beat is held unchanged.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_addr) && $stable(out_len)
                                      && $stable(out_last) && $stable(out_err));

    // R9: no input is taken while the divider works.
    a_r9_stall_divide: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> !in_ready);

    // R8: a good closing beat always reports at least one sub-segment.
    a_r8_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last && !out_err) |-> (out_count != '0));

endmodule

// File: tb/tb_seg_chunker.sv
module tb_seg_chunker;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic [15:0] in_len = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_addr;
    logic [12:0] out_len;
    logic        out_last;
    logic        out_err;
    logic [23:0] out_total;
    logic [9:0]  out_count;

    seg_chunker dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .in_len(in_len), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_len(out_len), .out_last(out_last), .out_err(out_err),
        .out_total(out_total), .out_count(out_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 0;

    int seg_addr [8];
    int seg_len  [8];
    int nseg;
    int exp_addr [MAXB];
    int exp_len  [MAXB];
    bit exp_last [MAXB];
    bit exp_err  [MAXB];
    bit exp_div  [MAXB];
    int exp_n;
    int exp_total;
    int exp_count;

    task automatic chk(bit ok, string tag, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    function automatic int piece(int rem);
        int m;
        if (rem <= 8191) return rem;
        m = (rem + 8187) / 8188;
        return (rem / m) & ~3;
    endfunction

    // Build the expected beats from seg_* per the requirements.
    task automatic build_expect();
        bit bad = 0;
        exp_n = 0; exp_total = 0; exp_count = 0;
        for (int i = 0; i < nseg && !bad; i++) begin
            if (seg_len[i] == 0 || (seg_addr[i] & 3) != 0) begin
                bad = 1;
            end else begin
                int rem = seg_len[i];
                int a = seg_addr[i];
                exp_total += seg_len[i];
                while (rem > 0) begin
                    int p = piece(rem);
                    exp_addr[exp_n] = a;
                    exp_len[exp_n]  = p;
                    exp_div[exp_n]  = (rem > 8191);
                    exp_err[exp_n]  = 0;
                    exp_last[exp_n] = (i == nseg - 1) && (p == rem);
                    a += p; rem -= p;
                    exp_n++; exp_count++;
                end
            end
        end
        if (bad) begin
            exp_addr[exp_n] = 0; exp_len[exp_n] = 0; exp_div[exp_n] = 0;
            exp_err[exp_n] = 1; exp_last[exp_n] = 1;
            exp_n++;
        end
    endtask

    task automatic drive_list();
        for (int i = 0; i < nseg; i++) begin
            int gap = $urandom % 3;
            for (int g = 0; g < gap; g++) begin
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_addr  = seg_addr[i];
            in_len   = 16'(seg_len[i]);
            in_last  = (i == nseg - 1);
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic watch_list();
        int k = 0;
        bit stalled = 0;
        logic [31:0] s_addr;
        logic [12:0] s_len;
        logic s_last;
        logic s_err;
        while (k < exp_n) begin
            @(negedge clk);
            if (stalled) begin
                chk(out_valid && out_addr == s_addr && out_len == s_len &&
                    out_last == s_last && out_err == s_err,
                    "R10 stalled beat held", out_len, s_len);
            end
            out_ready = ($urandom % 4) != 0;
            stalled = 0;
            if (out_valid) begin
                chk(!in_ready, "R9 input stalled while output valid", in_ready, 0);
                if (out_ready) begin
                    string t = exp_err[k] ? "R6 error beat" :
                               (exp_div[k] ? "R2 near-equal piece" : "R1 whole segment");
                    chk(out_len == exp_len[k], {t, " length"}, out_len, exp_len[k]);
                    chk(out_addr == 32'(exp_addr[k]), "R3 address advance", out_addr, exp_addr[k]);
                    chk(out_err == exp_err[k], "R6 error flag", out_err, exp_err[k]);
                    chk(out_last == exp_last[k], "R5 last flag", out_last, exp_last[k]);
                    if (exp_last[k]) begin
                        chk(out_total == 24'(exp_total), "R8 total", out_total, exp_total);
                        chk(out_count == 10'(exp_count), "R8 count", out_count, exp_count);
                    end
                    k++;
                end else begin
                    stalled = 1;
                    s_addr = out_addr; s_len = out_len; s_last = out_last; s_err = out_err;
                end
            end
        end
    endtask

    task automatic run_list();
        build_expect();
        @(posedge clk); #1;
        fork
            drive_list();
            watch_list();
        join
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 reset out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R11 reset in_ready", in_ready, 1);

        // R1: boundary, exactly the limit stays whole.
        nseg = 1; seg_addr[0] = 32'h1000; seg_len[0] = 8191; run_list();
        // R2: just above the limit, two equal halves.
        nseg = 1; seg_addr[0] = 32'h2000; seg_len[0] = 8192; run_list();
        // R2 R3: three pieces of a 16384-byte segment.
        nseg = 1; seg_addr[0] = 32'h8000; seg_len[0] = 16384; run_list();
        // R2: largest length.
        nseg = 2; seg_addr[0] = 32'h10000; seg_len[0] = 65535;
        seg_addr[1] = 32'h40; seg_len[1] = 3; run_list();
        // R7: empty list.
        nseg = 1; seg_addr[0] = 32'h100; seg_len[0] = 0; run_list();
        // R6: misaligned middle segment, rest drained.
        nseg = 4; seg_addr[0] = 32'h200; seg_len[0] = 9000;
        seg_addr[1] = 32'h4002; seg_len[1] = 100;
        seg_addr[2] = 32'h8000; seg_len[2] = 40;
        seg_addr[3] = 32'h9000; seg_len[3] = 20; run_list();
        // R6: zero-length segment after a good one, being the last.
        nseg = 2; seg_addr[0] = 32'h300; seg_len[0] = 50;
        seg_addr[1] = 32'h400; seg_len[1] = 0; run_list();
        // List after an error proceeds normally.
        nseg = 1; seg_addr[0] = 32'h500; seg_len[0] = 12; run_list();

        // Random lists.
        for (int l = 0; l < 40; l++) begin
            int kind = $urandom % 10;
            nseg = 1 + ($urandom % 5);
            for (int i = 0; i < nseg; i++) begin
                seg_addr[i] = ($urandom & 32'hFFFF_FFFC);
                seg_len[i]  = ($urandom % 3 == 0) ? 1 + ($urandom % 8191)
                                                  : 1 + ($urandom % 30000);
            end
            if (kind == 0) seg_addr[$urandom % nseg] |= 1 + ($urandom % 3);
            if (kind == 1) seg_len[$urandom % nseg] = 0;
            run_list();
        end

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule